// File: doc/BRIEF.md
# Flash command interface controller

This block is the control front end of a parallel NOR-style flash model. It watches the chip-enable, output-enable and write-enable strobes on the host bus. It filters out short glitches on those strobes and turns each clean write strobe into one write cycle. It steps through the unlock-and-command cycles that a program or an erase needs. When a sequence completes, it starts a stand-in operation timer and pulls its ready output low. The timer replaces the memory array and only counts clocks.

A hardware reset input, active low, reads as busy for as long as it is held low. If it stays low for a minimum number of clocks, it aborts any operation and returns the sequencer to read mode. Data output drive stays off during the reset and for a wake-up interval after the release. A digital supply-lockout input disables the command logic, forces read mode and discards writes while it is high.

All strobes and pins are sampled on the block clock. Every timing figure is given as a clock-count parameter.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the synchronous `rst`, the block is in read mode: `ready`=1, `dq_oe`=0, and `prog_go`, `erase_go`, `erase_chip`, `op_addr` and `op_data` are all 0.
- R2: A write cycle is registered only when the filtered write strobe rises while filtered chip-enable is low and filtered output-enable is high. The cycle carries the `addr`/`wdata` last seen while both the raw and filtered write strobes were low. `op_addr`/`op_data` report the values of the final cycle of a sequence.
- R3: A level change on `ce_n`, `oe_n` or `we_n` takes effect only after it has persisted for GLITCH_CLKS consecutive clocks. A shorter pulse starts no write cycle. A valid write holds `we_n` low for at least GLITCH_CLKS+1 clocks.
- R4: Program sequence: 0xAA at address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then one data write. Addresses compare on `addr[10:0]` and data on `wdata[7:0]`. The fourth cycle gives a one-clock `prog_go` and drives `ready` low on the clock after the filtered strobe rise.
- R5: Erase sequence: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then a sixth cycle. A sixth cycle of 0x30 at any address starts a sector erase with `erase_chip`=0. A sixth cycle of 0x10 at 0x555 starts a chip erase with `erase_chip`=1. Either one gives a one-clock `erase_go` and drives `ready` low.
- R6: A cycle that does not match the next expected address/data returns the sequencer to read mode with no operation started.
- R7: `ready` stays low for PROG_CLKS+1 or ERASE_CLKS+1 clocks from the start, then returns high. Write cycles made while busy are ignored.
- R8: `ready` is 0 on every clock that follows a clock on which `hw_reset_n` was sampled low.
- R9: A reset held low for RST_MIN_CLKS clocks aborts any operation, so `ready`=1 right after release. A shorter low pulse leaves a running operation busy.
- R10: `dq_oe` is 0 while `hw_reset_n` is low and for WAKE_CLKS clocks after it returns high.
- R11: While `lockout`=1, any operation is aborted, `ready`=1 (reset pin high), and all write cycles are discarded.
- R12: `dq_oe` is 1 only for a read: filtered chip-enable and output-enable low, write strobe high, and the device awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| lockout | input | 1 | Supply lockout flag, writes disabled when 1 |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| ready | output | 1 | Ready (1) / busy (0) |
| dq_oe | output | 1 | Data output drive enable (0 = tri-state) |
| prog_go | output | 1 | One-clock program start pulse |
| erase_go | output | 1 | One-clock erase start pulse |
| erase_chip | output | 1 | Last erase covers the whole chip |
| op_addr | output | ADDR_W | Address of the started operation |
| op_data | output | DATA_W | Data of the started operation |

## Verification
Several rules are checked by assertions on every clock:
- `ready` and `dq_oe` fall after a low reset sample.
- Output drive stays off on the clock after a release.
- The two start pulses never coincide.
- A start pulse always comes with busy.
- Lockout forces ready and suppresses starts.

Only the bench scenarios can show the rest, because each needs a history of many cycles:
- glitch rejection;
- the exact unlock ordering and mismatch recovery;
- busy duration;
- the short-versus-long reset distinction;
- the wake-up interval;
- writes discarded during busy or lockout.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_READ,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM_DATA,
    SQ_ERS_SETUP,
    SQ_ERS_UNL1,
    SQ_ERS_UNL2,
    SQ_BUSY
  } seq_state_t;

  localparam logic [10:0] ADR_FIRST  = 11'h555;
  localparam logic [10:0] ADR_SECOND = 11'h2AA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECTOR = 8'h30;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
  parameter int WIDTH       = 3,
  parameter int GLITCH_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] filt_n
);
  localparam int CW = (GLITCH_CLKS > 1) ? $clog2(GLITCH_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CLKS - 1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        lvl <= 1'b1;
      end else if (raw_n[i] == lvl) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        lvl <= raw_n[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign filt_n[i] = lvl;
  end
endmodule

// File: rtl/flash_reset_ctrl.sv
module flash_reset_ctrl #(
  parameter int RST_MIN_CLKS = 25,
  parameter int WAKE_CLKS    = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_reset_n,
  output logic pin_low,
  output logic abort,
  output logic awake
);
  localparam int LW = $clog2(RST_MIN_CLKS + 1);
  localparam int WW = $clog2(WAKE_CLKS + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(RST_MIN_CLKS - 1);
  localparam logic [LW-1:0] LOW_SAT  = LW'(RST_MIN_CLKS);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CLKS - 1);

  logic [LW-1:0] low_cnt;
  logic [WW-1:0] wake_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      wake_cnt <= '0;
      pin_low  <= 1'b0;
      abort    <= 1'b0;
      awake    <= 1'b1;
    end else begin
      pin_low <= ~hw_reset_n;
      abort   <= ~hw_reset_n && (low_cnt == LOW_LAST);
      if (hw_reset_n)
        low_cnt <= '0;
      else if (low_cnt != LOW_SAT)
        low_cnt <= low_cnt + 1'b1;
      if (!hw_reset_n) begin
        wake_cnt <= '0;
        awake    <= 1'b0;
      end else if (!awake) begin
        if (wake_cnt == WAKE_LAST)
          awake <= 1'b1;
        else
          wake_cnt <= wake_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int PROG_CLKS  = 40,
  parameter int ERASE_CLKS = 90
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic start,
  input  logic start_erase,
  output logic done
);
  localparam int MAXC = (PROG_CLKS > ERASE_CLKS) ? PROG_CLKS : ERASE_CLKS;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] LEN_P = TW'(PROG_CLKS);
  localparam logic [TW-1:0] LEN_E = TW'(ERASE_CLKS);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= start_erase ? LEN_E : LEN_P;
      done <= 1'b0;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      done <= (cnt == TW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              start,
  output logic              start_erase,
  output logic              rdy,
  output logic              prog_go,
  output logic              erase_go,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  seq_state_t st, st_n;
  logic       chip_n;
  logic       at_first, at_second;
  logic [7:0] key;

  assign at_first  = (wr_addr[10:0] == ADR_FIRST);
  assign at_second = (wr_addr[10:0] == ADR_SECOND);
  assign key       = wr_data[7:0];

  always_comb begin
    st_n        = st;
    start       = 1'b0;
    start_erase = 1'b0;
    chip_n      = 1'b0;
    if (kill) begin
      st_n = SQ_READ;
    end else if (st == SQ_BUSY) begin
      if (op_done) st_n = SQ_READ;
    end else if (wr_ok) begin
      st_n = SQ_READ;
      case (st)
        SQ_READ:      if (at_first && key == KEY_FIRST)   st_n = SQ_UNL1;
        SQ_UNL1:      if (at_second && key == KEY_SECOND) st_n = SQ_UNL2;
        SQ_UNL2: begin
          if (at_first && key == CMD_PROG)       st_n = SQ_PGM_DATA;
          else if (at_first && key == CMD_ERASE) st_n = SQ_ERS_SETUP;
        end
        SQ_PGM_DATA: begin
          start = 1'b1;
          st_n  = SQ_BUSY;
        end
        SQ_ERS_SETUP: if (at_first && key == KEY_FIRST)   st_n = SQ_ERS_UNL1;
        SQ_ERS_UNL1:  if (at_second && key == KEY_SECOND) st_n = SQ_ERS_UNL2;
        SQ_ERS_UNL2: begin
          if (key == CMD_SECTOR) begin
            start = 1'b1; start_erase = 1'b1; st_n = SQ_BUSY;
          end else if (at_first && key == CMD_CHIP) begin
            start = 1'b1; start_erase = 1'b1; chip_n = 1'b1; st_n = SQ_BUSY;
          end
        end
        default: st_n = SQ_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_READ;
      rdy        <= 1'b1;
      prog_go    <= 1'b0;
      erase_go   <= 1'b0;
      erase_chip <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      st       <= st_n;
      prog_go  <= start && !start_erase;
      erase_go <= start && start_erase;
      if (kill)
        rdy <= 1'b1;
      else if (start)
        rdy <= 1'b0;
      else if (st == SQ_BUSY && op_done)
        rdy <= 1'b1;
      if (start) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
        if (start_erase) erase_chip <= chip_n;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 16,
  parameter int GLITCH_CLKS  = 3,
  parameter int RST_MIN_CLKS = 25,
  parameter int WAKE_CLKS    = 25,
  parameter int PROG_CLKS    = 40,
  parameter int ERASE_CLKS   = 90
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_reset_n,
  input  logic              lockout,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              dq_oe,
  output logic              prog_go,
  output logic              erase_go,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  localparam int NSTB = 3;

  logic [NSTB-1:0] filt;
  logic f_ce, f_oe, f_we;
  logic we_prev, wr_evt, wr_ok, kill;
  logic pin_low, rst_abort, awake;
  logic start, start_erase, op_done, seq_rdy;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  strobe_filter #(.WIDTH(NSTB), .GLITCH_CLKS(GLITCH_CLKS)) u_filt (
    .clk(clk), .rst(rst), .raw_n({we_n, oe_n, ce_n}), .filt_n(filt)
  );
  assign f_ce = filt[0];
  assign f_oe = filt[1];
  assign f_we = filt[2];

  flash_reset_ctrl #(.RST_MIN_CLKS(RST_MIN_CLKS), .WAKE_CLKS(WAKE_CLKS)) u_rst (
    .clk(clk), .rst(rst), .hw_reset_n(hw_reset_n),
    .pin_low(pin_low), .abort(rst_abort), .awake(awake)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev  <= 1'b1;
      cap_addr <= '0;
      cap_data <= '0;
      dq_oe    <= 1'b0;
    end else begin
      we_prev <= f_we;
      if (!f_we && !we_n) begin
        cap_addr <= addr;
        cap_data <= wdata;
      end
      dq_oe <= hw_reset_n && awake && !f_ce && !f_oe && f_we;
    end
  end

  assign wr_evt = !we_prev && f_we && !f_ce && f_oe;
  assign wr_ok  = wr_evt && !pin_low && !lockout;
  assign kill   = rst_abort || lockout;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .kill(kill), .wr_ok(wr_ok),
    .wr_addr(cap_addr), .wr_data(cap_data), .op_done(op_done),
    .start(start), .start_erase(start_erase), .rdy(seq_rdy),
    .prog_go(prog_go), .erase_go(erase_go), .erase_chip(erase_chip),
    .op_addr(op_addr), .op_data(op_data)
  );

  flash_op_timer #(.PROG_CLKS(PROG_CLKS), .ERASE_CLKS(ERASE_CLKS)) u_tmr (
    .clk(clk), .rst(rst), .clear(kill), .start(start),
    .start_erase(start_erase), .done(op_done)
  );

  assign ready = seq_rdy && !pin_low;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hw_reset_n,
  input logic lockout,
  input logic ready,
  input logic dq_oe,
  input logic prog_go,
  input logic erase_go
);
  a_r8_busy_in_reset: assert property (@(posedge clk) disable iff (rst)
    !hw_reset_n |=> !ready);

  a_r10_tristate_in_reset: assert property (@(posedge clk) disable iff (rst)
    !hw_reset_n |=> !dq_oe);

  a_r10_wake_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(hw_reset_n) |=> !dq_oe);

  a_r4_go_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_go, erase_go}));

  a_r7_go_busy: assert property (@(posedge clk) disable iff (rst)
    (prog_go || erase_go) |-> !ready);

  a_r11_lockout_no_go: assert property (@(posedge clk) disable iff (rst)
    lockout |=> (!prog_go && !erase_go));

  a_r11_lockout_ready: assert property (@(posedge clk) disable iff (rst)
    (lockout && hw_reset_n) |=> ready);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .hw_reset_n(hw_reset_n), .lockout(lockout),
  .ready(ready), .dq_oe(dq_oe), .prog_go(prog_go), .erase_go(erase_go)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int GC = 3;
  localparam int RMIN = 25;
  localparam int WAKE = 25;
  localparam int PCLK = 40;
  localparam int ECLK = 90;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_reset_n = 1'b1, lockout = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, dq_oe, prog_go, erase_go, erase_chip;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CLKS(GC), .RST_MIN_CLKS(RMIN),
                   .WAKE_CLKS(WAKE), .PROG_CLKS(PCLK), .ERASE_CLKS(ECLK)) u0 (
    .clk(clk), .rst(rst), .hw_reset_n(hw_reset_n), .lockout(lockout),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .ready(ready), .dq_oe(dq_oe), .prog_go(prog_go), .erase_go(erase_go),
    .erase_chip(erase_chip), .op_addr(op_addr), .op_data(op_data)
  );

  int n_chk = 0, n_fail = 0;
  int pgo_cnt = 0, ego_cnt = 0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;
  logic last_chip = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int   m_fc[3];
  bit   m_f[3];
  bit   m_weprev, m_abort, m_pinlow, m_awake, m_busy, m_rdy, m_pgo, m_ego, m_chip, m_dqoe;
  int   m_low, m_wake, m_step, m_left;
  logic [AW-1:0] m_cap_a, m_oa;
  logic [DW-1:0] m_cap_d, m_od;

  always @(posedge clk) begin
    bit raw[3];
    bit evt, ok, kill, go, er;
    logic [10:0] a;
    logic [7:0] d;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_fc[i] = 0; m_f[i] = 1; end
      m_weprev = 1; m_abort = 0; m_pinlow = 0; m_awake = 1; m_busy = 0; m_rdy = 1;
      m_pgo = 0; m_ego = 0; m_chip = 0; m_dqoe = 0; m_low = 0; m_wake = 0;
      m_step = 0; m_left = 0; m_cap_a = '0; m_cap_d = '0; m_oa = '0; m_od = '0;
    end else begin
      raw[0] = ce_n; raw[1] = oe_n; raw[2] = we_n;
      evt  = !m_weprev && m_f[2] && !m_f[0] && m_f[1];
      ok   = evt && !m_pinlow && !lockout;
      kill = m_abort || lockout;
      m_pgo = 0; m_ego = 0; go = 0; er = 0;
      a = m_cap_a[10:0]; d = m_cap_d[7:0];
      if (kill) begin
        m_step = 0; m_busy = 0; m_left = 0; m_rdy = 1;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_rdy = 1; m_step = 0; end
      end else if (ok) begin
        case (m_step)
          0: m_step = (a == 11'h555 && d == 8'hAA) ? 1 : 0;
          1: m_step = (a == 11'h2AA && d == 8'h55) ? 2 : 0;
          2: m_step = (a == 11'h555 && d == 8'hA0) ? 10 :
                      (a == 11'h555 && d == 8'h80) ? 3 : 0;
          3: m_step = (a == 11'h555 && d == 8'hAA) ? 4 : 0;
          4: m_step = (a == 11'h2AA && d == 8'h55) ? 5 : 0;
          5: begin
            m_step = 0;
            if (d == 8'h30) begin go = 1; er = 1; m_chip = 0; end
            else if (a == 11'h555 && d == 8'h10) begin go = 1; er = 1; m_chip = 1; end
          end
          10: begin m_step = 0; go = 1; end
          default: m_step = 0;
        endcase
        if (go) begin
          m_busy = 1; m_rdy = 0; m_left = (er ? ECLK : PCLK) + 1;
          m_oa = m_cap_a; m_od = m_cap_d;
          if (er) m_ego = 1; else m_pgo = 1;
        end
      end
      m_dqoe = hw_reset_n && m_awake && !m_f[0] && !m_f[1] && m_f[2];
      if (!m_f[2] && !we_n) begin m_cap_a = addr; m_cap_d = wdata; end
      m_weprev = m_f[2];
      for (int i = 0; i < 3; i++) begin
        if (raw[i] == m_f[i]) m_fc[i] = 0;
        else if (m_fc[i] == GC - 1) begin m_f[i] = raw[i]; m_fc[i] = 0; end
        else m_fc[i]++;
      end
      m_abort = !hw_reset_n && (m_low == RMIN - 1);
      if (hw_reset_n) m_low = 0; else if (m_low != RMIN) m_low++;
      m_pinlow = !hw_reset_n;
      if (!hw_reset_n) begin m_wake = 0; m_awake = 0; end
      else if (!m_awake) begin
        if (m_wake == WAKE - 1) m_awake = 1; else m_wake++;
      end
    end
  end

  // per-clock comparison and start-pulse monitor
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 ready", 32'(ready), 32'(m_rdy && !m_pinlow));
      chk("R10 dq_oe", 32'(dq_oe), 32'(m_dqoe));
      chk("R4 prog_go", 32'(prog_go), 32'(m_pgo));
      chk("R5 erase_go", 32'(erase_go), 32'(m_ego));
      chk("R5 erase_chip", 32'(erase_chip), 32'(m_chip));
      chk("R2 op_addr", 32'(op_addr), 32'(m_oa));
      chk("R2 op_data", 32'(op_data), 32'(m_od));
      if (prog_go) begin pgo_cnt++; last_a = op_addr; last_d = op_data; end
      if (erase_go) begin ego_cnt++; last_a = op_addr; last_chip = erase_chip; end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int low_clks, input logic oe_lvl);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; oe_n = oe_lvl;
    @(negedge clk);
    we_n = 1'b0;
    idle(low_clks);
    we_n = 1'b1;
    idle(GC + 3);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr(a, d, GC + 1, 1'b1);
  endtask

  task automatic unlock();
    wr(19'h00555, 16'h00AA);
    wr(19'h002AA, 16'h0055);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 dq_oe", 32'(dq_oe), 32'd0);
    chk("R1 op_addr", 32'(op_addr), 32'd0);

    // R12 read enables drive
    ce_n = 1'b0; oe_n = 1'b0;
    idle(6);
    chk("R12 read drive", 32'(dq_oe), 32'd1);
    oe_n = 1'b1;
    idle(6);
    chk("R12 no drive", 32'(dq_oe), 32'd0);
    ce_n = 1'b1;
    idle(2);

    // R3 glitch-only sequence
    bus_wr(19'h00555, 16'h00AA, GC - 1, 1'b1);
    bus_wr(19'h002AA, 16'h0055, GC - 1, 1'b1);
    bus_wr(19'h00555, 16'h00A0, GC - 1, 1'b1);
    bus_wr(19'h00100, 16'h1234, GC - 1, 1'b1);
    idle(3);
    chk("R3 no start", 32'(pgo_cnt), 32'd0);
    chk("R3 ready", 32'(ready), 32'd1);

    // R4 program
    unlock();
    wr(19'h00555, 16'h00A0);
    wr(19'h12345, 16'hBEEF);
    chk("R4 busy", 32'(ready), 32'd0);
    chk("R4 started", 32'(pgo_cnt), 32'd1);
    chk("R2 addr", 32'(last_a), 32'h12345);
    chk("R2 data", 32'(last_d), 32'hBEEF);
    idle(PCLK + 5);
    chk("R7 ready again", 32'(ready), 32'd1);

    // R2 write with output enable low is not a cycle
    unlock();
    wr(19'h00555, 16'h00A0);
    bus_wr(19'h00111, 16'h0111, GC + 1, 1'b0);
    idle(2);
    chk("R2 oe low ignored", 32'(pgo_cnt), 32'd1);
    wr(19'h00222, 16'h0222);
    chk("R2 next cycle programs", 32'(last_a), 32'h00222);
    idle(PCLK + 5);

    // R6 mismatches
    wr(19'h00555, 16'h00AA);
    wr(19'h002AA, 16'h0056);
    wr(19'h00555, 16'h00A0);
    wr(19'h00010, 16'h0011);
    chk("R6 bad key", 32'(pgo_cnt), 32'd2);
    unlock();
    wr(19'h00555, 16'h0090);
    wr(19'h00010, 16'h0011);
    chk("R6 bad command", 32'(pgo_cnt + ego_cnt), 32'd2);

    // R5 sector erase, with writes during busy
    unlock();
    wr(19'h00555, 16'h0080);
    unlock();
    wr(19'h40000, 16'h0030);
    chk("R5 sector start", 32'(ego_cnt), 32'd1);
    chk("R5 sector flag", 32'(last_chip), 32'd0);
    chk("R5 sector addr", 32'(last_a), 32'h40000);
    unlock();
    wr(19'h00555, 16'h00A0);
    wr(19'h00333, 16'h0333);
    chk("R7 busy writes ignored", 32'(pgo_cnt), 32'd2);
    idle(ECLK);
    chk("R7 erase ends", 32'(ready), 32'd1);

    // R5 chip erase, R9 short reset pulse does not abort
    unlock();
    wr(19'h00555, 16'h0080);
    unlock();
    wr(19'h00555, 16'h0010);
    chk("R5 chip flag", 32'(last_chip), 32'd1);
    hw_reset_n = 1'b0;
    idle(10);
    chk("R8 busy in reset", 32'(ready), 32'd0);
    hw_reset_n = 1'b1;
    idle(2);
    chk("R9 short pulse keeps busy", 32'(ready), 32'd0);
    idle(ECLK + 40);
    chk("R7 chip erase ends", 32'(ready), 32'd1);

    // R9 long reset aborts program, R10 tri-state and wake-up
    unlock();
    wr(19'h00555, 16'h00A0);
    wr(19'h00444, 16'h0444);
    ce_n = 1'b0; oe_n = 1'b0;
    hw_reset_n = 1'b0;
    idle(20);
    chk("R8 ready low", 32'(ready), 32'd0);
    chk("R10 off in reset", 32'(dq_oe), 32'd0);
    idle(10);
    hw_reset_n = 1'b1;
    idle(2);
    chk("R9 aborted ready", 32'(ready), 32'd1);
    idle(8);
    chk("R10 off in wake", 32'(dq_oe), 32'd0);
    idle(WAKE);
    chk("R10 awake drive", 32'(dq_oe), 32'd1);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(3);

    // R11 lockout aborts and blocks writes
    unlock();
    wr(19'h00555, 16'h00A0);
    wr(19'h00555, 16'h0555);
    chk("R11 started", 32'(pgo_cnt), 32'd4);
    lockout = 1'b1;
    idle(2);
    chk("R11 ready under lockout", 32'(ready), 32'd1);
    unlock();
    wr(19'h00555, 16'h00A0);
    wr(19'h00666, 16'h0666);
    chk("R11 writes discarded", 32'(pgo_cnt), 32'd4);
    lockout = 1'b0;
    idle(3);
    chk("R11 ready after", 32'(ready), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule